// File: doc/BRIEF.md
# Flagged Ripple Adder/Subtractor

A purely combinational two's-complement adder/subtractor over two 4-bit operands. A single mode input picks addition or subtraction. For subtraction it inverts every bit of the second operand and also supplies the carry into the least significant stage, which adds the +1 that completes the negation. The datapath is a chain of identical 1-bit full-adder cells, with each carry feeding the next stage.

Alongside the 4-bit result the block reports five status flags: signed overflow, carry out of the top stage, zero result, negative result and odd result. There is no clock and no state. Every output follows the present inputs after the ripple delay, so the block can sit inside any pipeline stage that needs integer add or subtract with condition codes.

Top module: `flagged_addsub`

## Requirements
- R1: With sub_i = 0, sum_o equals (x_i + y_i) modulo 16.
- R2: With sub_i = 1, sum_o equals (x_i - y_i) modulo 16.
- R3: carry_o is the carry leaving bit 3 of the chain. When adding it is 1 exactly when x_i + y_i > 15 unsigned. When subtracting it is 1 exactly when x_i >= y_i unsigned.
- R4: ovf_o is 1 exactly when the true signed result, with operands read as two's complement in -8..7, lies outside -8..7.
- R5: zero_o is 1 exactly when all four bits of sum_o are 0.
- R6: neg_o equals bit 3 of sum_o. After an overflow this bit is not corrected toward the sign of the true result.
- R7: odd_o equals bit 0 of sum_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 4 | First operand, two's complement, bit 3 is the sign |
| y_i | input | 4 | Second operand, two's complement, bit 3 is the sign |
| sub_i | input | 1 | 0 selects add, 1 selects subtract; also the carry into bit 0 |
| sum_o | output | 4 | Result bits |
| ovf_o | output | 1 | Signed overflow |
| carry_o | output | 1 | Carry out of the most significant stage |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result sign bit is set |
| odd_o | output | 1 | Result is odd |

## Verification
The immediate assertions assume that the inputs are fully defined 2-state values and that they are evaluated only after the combinational chain has settled. Under these assumptions the outputs are a pure function of x_i, y_i and sub_i. The stimulus holds each input vector steady for several nanoseconds before any sampling. It steps through all 512 combinations of operands and mode, so no output is ever read during a transition. Because every pattern is applied, every carry, overflow and sign corner is covered, including -8 minus any value and 0 minus 0.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef struct packed {
    logic ovf;
    logic carry;
    logic zero;
    logic neg;
    logic odd;
  } status_t;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic half;
  assign half = a_i ^ b_i;
  assign s_o  = half ^ c_i;
  assign c_o  = (a_i & b_i) | (half & c_i);
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_o,
  output logic         c_pre_o
);
  logic [W:0] cy;
  assign cy[0] = cin_i;

  for (genvar g = 0; g < W; g++) begin : g_stage
    fa_cell u_fa (
      .a_i(a_i[g]),
      .b_i(b_i[g]),
      .c_i(cy[g]),
      .s_o(sum_o[g]),
      .c_o(cy[g+1])
    );
  end

  assign c_msb_o = cy[W];
  assign c_pre_o = cy[W-1];
endmodule

// File: rtl/status_unit.sv
module status_unit
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] sum_i,
  input  logic         c_msb_i,
  input  logic         c_pre_i,
  output status_t      st_o
);
  always_comb begin
    st_o.ovf   = c_msb_i ^ c_pre_i;
    st_o.carry = c_msb_i;
    st_o.zero  = ~|sum_i;
    st_o.neg   = sum_i[W-1];
    st_o.odd   = sum_i[0];
  end

  // a zero result can never carry a set sign bit
  always_comb begin
    a_r6_neg_not_zero: assert (!(st_o.neg && st_o.zero));
  end
endmodule

// File: rtl/flagged_addsub.sv
module flagged_addsub
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         odd_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] y_eff;
  logic         c_msb, c_pre;
  status_t      st;

  // conditional inversion of the second operand
  assign y_eff = y_i ^ {W{sub_i}};

  ripple_chain #(.W(W)) u_chain (
    .a_i    (x_i),
    .b_i    (y_eff),
    .cin_i  (sub_i),
    .sum_o  (sum_o),
    .c_msb_o(c_msb),
    .c_pre_o(c_pre)
  );

  status_unit #(.W(W)) u_status (
    .sum_i  (sum_o),
    .c_msb_i(c_msb),
    .c_pre_i(c_pre),
    .st_o   (st)
  );

  assign ovf_o   = st.ovf;
  assign carry_o = st.carry;
  assign zero_o  = st.zero;
  assign neg_o   = st.neg;
  assign odd_o   = st.odd;

  logic [W:0] add_ref, sub_ref;
  assign add_ref = {1'b0, x_i} + {1'b0, y_i};
  assign sub_ref = {1'b0, x_i} - {1'b0, y_i};

  always_comb begin
    if (!sub_i) begin
      a_r1_add_sum: assert (sum_o == add_ref[W-1:0]);
      a_r3_add_carry: assert (carry_o == add_ref[W]);
    end else begin
      a_r2_sub_sum: assert (sum_o == sub_ref[W-1:0]);
      a_r3_sub_carry: assert (carry_o == (x_i >= y_i));
    end
    a_r4_sign_ovf: assert (ovf_o == ((x_i[MSB] == y_eff[MSB]) && (sum_o[MSB] != x_i[MSB])));
    a_r7_odd_parity: assert (odd_o == (x_i[0] ^ y_i[0]));
    a_r5_zero_match: assert (zero_o == (sub_i ? (x_i == y_i) : (add_ref[W-1:0] == '0)));
  end
endmodule

// File: tb/flagged_addsub_tb.sv
module flagged_addsub_tb;
  logic       clk = 1'b0;
  logic [3:0] x, y;
  logic       sub;
  logic [3:0] sum;
  logic       ovf, cy, zf, nf, of;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz time reference only

  flagged_addsub u_dut (
    .x_i(x), .y_i(y), .sub_i(sub),
    .sum_o(sum), .ovf_o(ovf), .carry_o(cy),
    .zero_o(zf), .neg_o(nf), .odd_o(of)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s x=%0d y=%0d sub=%0d actual=%0d expected=%0d", req, x, y, sub, act, exp);
    end
  endtask

  initial begin
    x = 4'd0; y = 4'd0; sub = 1'b0;
    #5;
    // all-zero inputs: R1 R5
    chk("R1", sum, 0);
    chk("R5", zf, 1);
    for (int k = 0; k < 512; k++) begin
      int xs, ys, r, er, ec;
      x   = k[3:0];
      y   = k[7:4];
      sub = k[8];
      #5;
      xs = (int'(x) >= 8) ? int'(x) - 16 : int'(x);
      ys = (int'(y) >= 8) ? int'(y) - 16 : int'(y);
      r  = sub ? xs - ys : xs + ys;
      er = r & 15;
      ec = sub ? ((int'(x) + (15 - int'(y)) + 1) > 15 ? 1 : 0)
               : ((int'(x) + int'(y)) > 15 ? 1 : 0);
      chk(sub ? "R2" : "R1", sum, er);
      chk("R3", cy, ec);
      chk("R4", ovf, (r > 7 || r < -8) ? 1 : 0);
      chk("R5", zf, (er == 0) ? 1 : 0);
      chk("R6", nf, (er >= 8) ? 1 : 0);
      chk("R7", of, er & 1);
      #5;
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule